// File: doc/BRIEF.md
# Receive-Level and Clear-to-Send Flow Controller

This block sits next to a serial transmitter and a receive FIFO. From the FIFO fill count it drives an active-low request-to-send line (`rts_n`). The line goes inactive (high) when the FIFO reaches a selected trigger level. It becomes active (low) again only after the FIFO has drained to a lower partner level. The gap between the two levels gives hysteresis, so the line does not toggle on every character. The same fill comparison drives a level interrupt request. The FIFO itself keeps taking data while the line is inactive, until it is full.

In the other direction, the block watches an active-low clear-to-send input from the remote end. The input is synchronized first. When it goes high, the block withdraws permission to start new characters. It only does so at a character boundary that the transmitter reports, so no frame is ever cut short. When the input goes low again, permission returns. A rising edge on the synchronized input can also latch an interrupt flag, which stays set until the host clears it.

Top module: `uart_flow_ctl`

## Requirements
- R1: After synchronous reset, `rts_n` is 0, `tx_allow` is 1, and `cts_irq` and `trig_irq` are 0.
- R2: `trig_sel` selects the upper level. With a depth of 32, the codes 0, 1, 2 and 3 select 8, 16, 24 and 28. `trig_irq` equals (`rx_count` >= upper level) one cycle after the count is presented.
- R3: When `rts_en` is 1 and `rx_count` >= upper level, `rts_n` is 1 on the next cycle.
- R4: When `rts_en` is 1, `rts_n` returns to 0 the cycle after `rx_count` <= lower level. The lower levels are 0, 7, 15 and 23 for codes 0, 1, 2 and 3. Strictly between the two levels, `rts_n` holds its value.
- R5: When `rts_en` is 0, `rts_n` is 0 one cycle later, whatever the count.
- R6: A 0-to-1 change on `cts_n_in` sets `cts_irq` three cycles after the pin changes, if `cts_irq_en` is 1. Two cycles of this are the synchronizer and one is the flag register. The flag stays set until a `cts_irq_clr` pulse, which clears it on the next cycle. A 1-to-0 change does not set it.
- R7: With `cts_irq_en` at 0, a rising CTS edge leaves `cts_irq` at 0.
- R8: With `cts_en` at 1 and synchronized CTS high, `tx_allow` stays 1 until `tx_boundary` is seen high. It is 0 on the cycle after that strobe. The transmitter pulses `tx_boundary` when a stop bit completes, and holds it high while idle.
- R9: With `cts_en` at 1, `tx_allow` returns to 1 three cycles after `cts_n_in` falls to 0. It is still 0 two cycles after the fall.
- R10: With `cts_en` at 0, `tx_allow` is 1 one cycle later and stays 1, whatever the CTS input or the boundary strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | CNT_W (6) | Receive FIFO fill count |
| trig_sel | input | 2 | Trigger level select code |
| rts_en | input | 1 | Enables automatic RTS control |
| cts_en | input | 1 | Enables automatic CTS transmit gating |
| cts_irq_en | input | 1 | Enables setting of the CTS change flag |
| cts_irq_clr | input | 1 | Host pulse that clears the CTS change flag |
| cts_n_in | input | 1 | Asynchronous active-low clear-to-send pin |
| tx_boundary | input | 1 | Transmitter is at a character boundary |
| rts_n | output | 1 | Active-low request-to-send pin |
| tx_allow | output | 1 | Transmitter may start a new character |
| cts_irq | output | 1 | Latched CTS rising-edge flag |
| trig_irq | output | 1 | Receive fill at or above the trigger level |

## Verification
The count-driven outputs `rts_n` and `trig_irq` are due one cycle after a new count or select value. The CTS flag and the resume of `tx_allow` are due three cycles after a pin change, and a boundary-driven pause is due one cycle after the strobe. Each stimulus is applied half a cycle before an edge. Along with it, the bench queues the expected value, tagged with the exact cycle number at which the result is due. A monitor compares the output at the falling edge of that cycle. Extra early samples, such as the value two cycles after a CTS fall, confirm that results do not arrive sooner than stated.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;

  // Upper (stop) level for a trigger code, scaled from the FIFO depth.
  function automatic int hi_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return depth - 4;
    endcase
  endfunction

  // Lower (restart) level paired with each trigger code.
  function automatic int lo_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return 0;
      2'd1:    return depth / 4 - 1;
      2'd2:    return depth / 2 - 1;
      default: return (3 * depth) / 4 - 1;
    endcase
  endfunction

endpackage

// File: rtl/rx_level_watch.sv
module rx_level_watch #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             rts_en,
  output logic             rts_n,
  output logic             trig_irq
);
  logic [CNT_W-1:0] hi_lvl, lo_lvl;
  logic             at_hi, at_lo;

  always_comb begin
    hi_lvl = CNT_W'(flow_ctl_pkg::hi_level(trig_sel, DEPTH));
    lo_lvl = CNT_W'(flow_ctl_pkg::lo_level(trig_sel, DEPTH));
    at_hi  = (rx_count >= hi_lvl);
    at_lo  = (rx_count <= lo_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n    <= 1'b0;
      trig_irq <= 1'b0;
    end else begin
      trig_irq <= at_hi;
      if (!rts_en)    rts_n <= 1'b0;
      else if (at_hi) rts_n <= 1'b1;
      else if (at_lo) rts_n <= 1'b0;
    end
  end
endmodule

// File: rtl/cts_sync_edge.sv
module cts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dsync,
  output logic drise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign dsync = chain[STAGES-1];
  assign drise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tx_pause_gate.sv
module tx_pause_gate (
  input  logic clk,
  input  logic rst,
  input  logic cts_en,
  input  logic cts_hold,
  input  logic tx_boundary,
  output logic tx_allow
);
  always_ff @(posedge clk) begin
    if (rst)                        tx_allow <= 1'b1;
    else if (!cts_en || !cts_hold)  tx_allow <= 1'b1;
    else if (tx_boundary)           tx_allow <= 1'b0;
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             rts_en,
  input  logic             cts_en,
  input  logic             cts_irq_en,
  input  logic             cts_irq_clr,
  input  logic             cts_n_in,
  input  logic             tx_boundary,
  output logic             rts_n,
  output logic             tx_allow,
  output logic             cts_irq,
  output logic             trig_irq
);
  logic cts_s, cts_rise;

  rx_level_watch #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
    .rts_en(rts_en), .rts_n(rts_n), .trig_irq(trig_irq)
  );

  cts_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cts_n_in), .dsync(cts_s), .drise(cts_rise)
  );

  tx_pause_gate u_gate (
    .clk(clk), .rst(rst), .cts_en(cts_en), .cts_hold(cts_s),
    .tx_boundary(tx_boundary), .tx_allow(tx_allow)
  );

  // A new edge takes precedence over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                           cts_irq <= 1'b0;
    else if (cts_rise && cts_irq_en)   cts_irq <= 1'b1;
    else if (cts_irq_clr)              cts_irq <= 1'b0;
  end
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rx_count,
  input logic [1:0]       trig_sel,
  input logic             rts_en,
  input logic             cts_en,
  input logic             cts_irq_en,
  input logic             cts_irq_clr,
  input logic             tx_boundary,
  input logic             rts_n,
  input logic             tx_allow,
  input logic             cts_irq,
  input logic             trig_irq
);
  logic [CNT_W-1:0] hi_c, lo_c;
  always_comb begin
    hi_c = CNT_W'(flow_ctl_pkg::hi_level(trig_sel, DEPTH));
    lo_c = CNT_W'(flow_ctl_pkg::lo_level(trig_sel, DEPTH));
  end

  p_trig_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_count >= hi_c) |=> trig_irq);
  p_trig_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_count < hi_c) |=> !trig_irq);
  p_rts_off_r3: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rx_count >= hi_c) |=> rts_n);
  p_rts_on_r4: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rx_count <= lo_c) |=> !rts_n);
  p_rts_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rx_count > lo_c && rx_count < hi_c) |=> (rts_n == $past(rts_n)));
  p_rts_dis_r5: assert property (@(posedge clk) disable iff (rst)
    !rts_en |=> !rts_n);
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cts_irq && !cts_irq_clr) |=> cts_irq);
  p_flag_off_r7: assert property (@(posedge clk) disable iff (rst)
    (!cts_irq_en && !cts_irq) |=> !cts_irq);
  p_pause_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_allow) |-> ($past(tx_boundary) && $past(cts_en)));
  p_no_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !cts_en |=> tx_allow);
endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
  .rts_en(rts_en), .cts_en(cts_en), .cts_irq_en(cts_irq_en),
  .cts_irq_clr(cts_irq_clr), .tx_boundary(tx_boundary), .rts_n(rts_n),
  .tx_allow(tx_allow), .cts_irq(cts_irq), .trig_irq(trig_irq)
);

// File: tb/tb_uart_flow_ctl.sv
module tb_uart_flow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  localparam int S_RTS = 0, S_ALLOW = 1, S_CIRQ = 2, S_TRIG = 3;

  typedef struct {
    int    due;
    int    sig;
    logic  exp;
    string req;
  } item_t;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] rx_count;
  logic [1:0]       trig_sel;
  logic             rts_en, cts_en, cts_irq_en, cts_irq_clr, cts_n_in, tx_boundary;
  logic             rts_n, tx_allow, cts_irq, trig_irq;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  item_t q[$];

  uart_flow_ctl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
    .rts_en(rts_en), .cts_en(cts_en), .cts_irq_en(cts_irq_en),
    .cts_irq_clr(cts_irq_clr), .cts_n_in(cts_n_in), .tx_boundary(tx_boundary),
    .rts_n(rts_n), .tx_allow(tx_allow), .cts_irq(cts_irq), .trig_irq(trig_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sig_val(input int s);
    case (s)
      S_RTS:   return rts_n;
      S_ALLOW: return tx_allow;
      S_CIRQ:  return cts_irq;
      default: return trig_irq;
    endcase
  endfunction

  function automatic string sig_name(input int s);
    case (s)
      S_RTS:   return "rts_n";
      S_ALLOW: return "tx_allow";
      S_CIRQ:  return "cts_irq";
      default: return "trig_irq";
    endcase
  endfunction

  task automatic compare(input int s, input logic e, input string req);
    checks++;
    if (sig_val(s) !== e) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d",
               req, sig_name(s), sig_val(s), e, cyc);
    end
  endtask

  // Driver side: queue an expectation due d clock edges from now.
  task automatic expect_in(input int s, input logic e, input int d, input string req);
    item_t it;
    it.due = cyc + d; it.sig = s; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every queued item whose cycle has come.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        compare(q[i].sig, q[i].exp, q[i].req);
        q.delete(i);
      end
    end
  end

  task automatic set_count(input int c, input logic rts_exp, input logic trig_exp, input string req);
    rx_count = CNT_W'(c);
    expect_in(S_RTS, rts_exp, 1, req);
    expect_in(S_TRIG, trig_exp, 1, "R2");
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_count = '0; trig_sel = 2'd0; rts_en = 1'b0; cts_en = 1'b0;
    cts_irq_en = 1'b0; cts_irq_clr = 1'b0; cts_n_in = 1'b0; tx_boundary = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    compare(S_RTS, 1'b0, "R1");
    compare(S_ALLOW, 1'b1, "R1");
    compare(S_CIRQ, 1'b0, "R1");
    compare(S_TRIG, 1'b0, "R1");

    rts_en = 1'b1;
    // code 0: levels 8 / 0
    trig_sel = 2'd0;
    set_count(7, 1'b0, 1'b0, "R3");
    set_count(8, 1'b1, 1'b1, "R3");
    set_count(3, 1'b1, 1'b0, "R4");
    set_count(0, 1'b0, 1'b0, "R4");
    // code 1: levels 16 / 7
    trig_sel = 2'd1;
    set_count(15, 1'b0, 1'b0, "R3");
    set_count(16, 1'b1, 1'b1, "R3");
    set_count(8, 1'b1, 1'b0, "R4");
    set_count(7, 1'b0, 1'b0, "R4");
    // code 2: levels 24 / 15
    trig_sel = 2'd2;
    set_count(24, 1'b1, 1'b1, "R3");
    set_count(16, 1'b1, 1'b0, "R4");
    set_count(15, 1'b0, 1'b0, "R4");
    // code 3: levels 28 / 23
    trig_sel = 2'd3;
    set_count(27, 1'b0, 1'b0, "R3");
    set_count(28, 1'b1, 1'b1, "R3");
    set_count(24, 1'b1, 1'b0, "R4");
    set_count(23, 1'b0, 1'b0, "R4");
    set_count(32, 1'b1, 1'b1, "R3");
    // R5 disable forces RTS active, level interrupt unaffected
    rts_en = 1'b0;
    set_count(32, 1'b0, 1'b1, "R5");

    // CTS path
    cts_en = 1'b1; cts_irq_en = 1'b1; tx_boundary = 1'b0;
    cts_n_in = 1'b1;
    expect_in(S_CIRQ, 1'b0, 2, "R6");
    expect_in(S_CIRQ, 1'b1, 3, "R6");
    expect_in(S_ALLOW, 1'b1, 3, "R8");
    expect_in(S_ALLOW, 1'b1, 5, "R8");
    tick(6);
    tx_boundary = 1'b1;
    expect_in(S_ALLOW, 1'b0, 1, "R8");
    tick(1);
    tx_boundary = 1'b0;
    expect_in(S_ALLOW, 1'b0, 2, "R8");
    expect_in(S_CIRQ, 1'b1, 2, "R6");
    tick(3);
    cts_irq_clr = 1'b1;
    expect_in(S_CIRQ, 1'b0, 1, "R6");
    tick(1);
    cts_irq_clr = 1'b0;
    tick(1);
    cts_n_in = 1'b0;
    expect_in(S_ALLOW, 1'b0, 2, "R9");
    expect_in(S_ALLOW, 1'b1, 3, "R9");
    expect_in(S_CIRQ, 1'b0, 4, "R6");
    tick(6);
    // R7 flag disabled
    cts_irq_en = 1'b0;
    cts_n_in = 1'b1;
    expect_in(S_CIRQ, 1'b0, 3, "R7");
    expect_in(S_CIRQ, 1'b0, 5, "R7");
    tick(6);
    // R10 gating disabled while CTS high and boundary present
    cts_en = 1'b0;
    tx_boundary = 1'b1;
    expect_in(S_ALLOW, 1'b1, 1, "R10");
    expect_in(S_ALLOW, 1'b1, 3, "R10");
    tick(4);
    cts_en = 1'b1;
    expect_in(S_ALLOW, 1'b0, 1, "R8");
    tick(2);
    cts_n_in = 1'b0;
    expect_in(S_ALLOW, 1'b1, 3, "R9");
    tick(6);

    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule